// File: doc/BRIEF.md
# Configurable Serial Audio Input Deserializer

This block turns a two-channel serial PCM stream into parallel samples. The stream arrives on three wires: a bit clock, a frame clock that tells the two channels apart, and a data line. All three are brought into the system clock domain and the rising edges of the bit clock are detected there. Each channel slot carries one 16-bit two's-complement sample. The rest of the slot is filler and is discarded.

Three static configuration inputs set how the slot is read. The first picks a 24-bit or 32-bit slot per channel. The second picks the arrival order of the data bits, most significant first or least significant first. The third picks which half of a 32-bit slot holds the sample. A 24-bit slot always carries its sample in its last 16 bits. Once a channel-2 sample is complete, both samples appear together on registered outputs, and a single-cycle strobe marks them.

Top module: `serial_audio_deser`

## Requirements
- R1: While `rst` is high on a clock edge, `ch1_o` and `ch2_o` become zero, `valid_o` becomes low, and the slot position is forgotten, so the next sample is only taken after a frame-clock change.
- R2: Data and frame-clock levels are taken on each rising edge of the bit clock. A frame-clock level of 1 marks channel 1 and a level of 0 marks channel 2. A bit whose frame-clock level differs from the previous bit's level is position 0 of a new slot.
- R3: With `slot32_i` = 0 (24-bit slot), the sample occupies slot positions 8 to 23, whatever the level of `front_i`.
- R4: With `slot32_i` = 1 (32-bit slot), the sample occupies positions 0 to 15 when `front_i` = 1 and positions 16 to 31 when `front_i` = 0.
- R5: With `msb_first_i` = 1, the first sample bit received is bit 15. With `msb_first_i` = 0, the first sample bit received is bit 0.
- R6: Bits at slot positions outside the sample field have no effect on either output sample.
- R7: `valid_o` is high for exactly one system clock cycle per completed frame. `ch1_o` and `ch2_o` change only in that cycle and hold their values at all other times.
- R8: A completed channel-2 sample raises `valid_o` only if a channel-1 sample has been completed since the previous strobe. Otherwise the outputs keep their old values.
- R9: A frame-clock change in the middle of a slot restarts the position count, so a cut-short slot does not shift the alignment of later slots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bclk_i | input | 1 | Serial bit clock, asynchronous |
| lrck_i | input | 1 | Frame clock: 1 = channel 1, 0 = channel 2 |
| sdata_i | input | 1 | Serial data line |
| slot32_i | input | 1 | Slot size: 0 = 24-bit, 1 = 32-bit |
| msb_first_i | input | 1 | Bit order: 1 = MSB first, 0 = LSB first |
| front_i | input | 1 | 32-bit slot placement: 1 = first half, 0 = second half |
| ch1_o | output | 16 | Channel-1 sample |
| ch2_o | output | 16 | Channel-2 sample |
| valid_o | output | 1 | One-cycle strobe when a new sample pair appears |

## Verification
The bench fills every non-sample position with a bit pattern and then repeats the frame with that pattern inverted. A field window that is off by one or more positions picks up filler bits and returns a different word on one of the two runs. The 24-bit case is also run with the placement input high; a design that lets placement act on short slots reads positions 0 to 15 and returns garbage. One frame carries a channel-1 slot cut short after four bits, followed by a full channel-2 slot. A design that pairs samples without checking for channel-1 completion strobes stale data here, and a design that does not restart its count on the frame-clock change misreads the frame after it. The samples are asymmetric values with the sign bit both set and clear, so a reversed bit order or a missing sign bit shows up in the output.

// File: rtl/sad_pkg.sv
package sad_pkg;
  localparam int SAMPLE_W   = 16;
  localparam int SLOT_SHORT = 24;
  localparam int SLOT_LONG  = 32;

  // bundle of asynchronous pins passed through the synchronizer
  typedef struct packed {
    logic bclk;
    logic lrck;
    logic sdata;
    logic slot32;
    logic msb_first;
    logic front;
  } pins_t;
endpackage

// File: rtl/sad_sync.sv
module sad_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sad_slot.sv
module sad_slot
  import sad_pkg::*;
#(
  parameter int SW = SAMPLE_W,
  parameter int SA = SLOT_SHORT,
  parameter int SB = SLOT_LONG
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_stb,
  input  logic          lr,
  input  logic          sd,
  input  logic          slot32,
  input  logic          msb_first,
  input  logic          front,
  output logic          done,
  output logic          done_ch1,
  output logic [SW-1:0] word
);
  localparam int CW = $clog2(SB) + 1;
  localparam logic [CW-1:0] POS_IDLE = '1;
  localparam logic [CW-1:0] START_A  = CW'(SA - SW);
  localparam logic [CW-1:0] START_BR = CW'(SB - SW);
  localparam logic [CW-1:0] START_BF = '0;
  localparam logic [CW-1:0] LAST_OFS = CW'(SW - 1);

  logic [CW-1:0] cnt, pos, start_pos, end_pos;
  logic          lr_prev, restart, in_field, last_bit;
  logic [SW-1:0] sh, sh_next;

  always_comb begin
    restart = bit_stb && (lr != lr_prev);
    pos     = restart ? '0 : cnt;
    if (!slot32)    start_pos = START_A;
    else if (front) start_pos = START_BF;
    else            start_pos = START_BR;
    end_pos  = start_pos + LAST_OFS;
    in_field = bit_stb && (pos >= start_pos) && (pos <= end_pos);
    last_bit = in_field && (pos == end_pos);
    sh_next  = msb_first ? {sh[SW-2:0], sd} : {sd, sh[SW-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= POS_IDLE;
      lr_prev  <= 1'b0;
      sh       <= '0;
      done     <= 1'b0;
      done_ch1 <= 1'b0;
      word     <= '0;
    end else begin
      done <= last_bit;
      if (bit_stb) begin
        lr_prev <= lr;
        if (restart)              cnt <= CW'(1);
        else if (cnt != POS_IDLE) cnt <= cnt + 1'b1;
      end
      if (in_field) sh <= sh_next;
      if (last_bit) begin
        word     <= sh_next;
        done_ch1 <= lr;
      end
    end
  end

  // a finished field always follows a bit-clock edge one cycle earlier
  property p_done_after_bit;
    @(posedge clk) disable iff (rst) done |-> $past(bit_stb);
  endproperty
  assert_done_after_bit_R2: assert property (p_done_after_bit);
endmodule

// File: rtl/serial_audio_deser.sv
module serial_audio_deser
  import sad_pkg::*;
#(
  parameter int SAMPLE_BITS = SAMPLE_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bclk_i,
  input  logic                   lrck_i,
  input  logic                   sdata_i,
  input  logic                   slot32_i,
  input  logic                   msb_first_i,
  input  logic                   front_i,
  output logic [SAMPLE_BITS-1:0] ch1_o,
  output logic [SAMPLE_BITS-1:0] ch2_o,
  output logic                   valid_o
);
  localparam int PW = $bits(pins_t);

  pins_t raw, syn;
  logic  bclk_q, bit_stb;
  logic  done, done_ch1, ch1_ok;
  logic [SAMPLE_BITS-1:0] word, ch1_hold;

  assign raw = '{bclk: bclk_i, lrck: lrck_i, sdata: sdata_i,
                 slot32: slot32_i, msb_first: msb_first_i, front: front_i};

  sad_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw),
    .q   (syn)
  );

  always_ff @(posedge clk) begin
    if (rst) bclk_q <= 1'b0;
    else     bclk_q <= syn.bclk;
  end
  assign bit_stb = syn.bclk & ~bclk_q;

  sad_slot #(.SW(SAMPLE_BITS)) u_slot (
    .clk       (clk),
    .rst       (rst),
    .bit_stb   (bit_stb),
    .lr        (syn.lrck),
    .sd        (syn.sdata),
    .slot32    (syn.slot32),
    .msb_first (syn.msb_first),
    .front     (syn.front),
    .done      (done),
    .done_ch1  (done_ch1),
    .word      (word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ch1_hold <= '0;
      ch1_ok   <= 1'b0;
      ch1_o    <= '0;
      ch2_o    <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (done && done_ch1) begin
        ch1_hold <= word;
        ch1_ok   <= 1'b1;
      end else if (done && ch1_ok) begin
        ch1_o   <= ch1_hold;
        ch2_o   <= word;
        valid_o <= 1'b1;
        ch1_ok  <= 1'b0;
      end
    end
  end

  property p_edge_gap;
    @(posedge clk) disable iff (rst) bit_stb |=> !bit_stb;
  endproperty
  assert_edge_gap_R2: assert property (p_edge_gap);

  property p_strobe_one;
    @(posedge clk) disable iff (rst) valid_o |=> !valid_o;
  endproperty
  assert_strobe_one_R7: assert property (p_strobe_one);

  property p_hold;
    @(posedge clk) disable iff (rst) !valid_o |-> ($stable(ch1_o) && $stable(ch2_o));
  endproperty
  assert_hold_R7: assert property (p_hold);

  property p_pair;
    @(posedge clk) disable iff (rst) valid_o |-> $past(done && !done_ch1);
  endproperty
  assert_pair_R8: assert property (p_pair);
endmodule

// File: tb/serial_audio_deser_test.sv
module serial_audio_deser_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bclk = 1'b0, lrck = 1'b0, sdata = 1'b0;
  logic slot32 = 1'b0, msb_first = 1'b1, front = 1'b0;
  logic [15:0] ch1, ch2;
  logic valid;
  int checks = 0, errors = 0, vcount = 0, wide = 0;
  logic prev_v = 1'b0;

  always #4 clk = ~clk;

  serial_audio_deser uut (
    .clk(clk), .rst(rst), .bclk_i(bclk), .lrck_i(lrck), .sdata_i(sdata),
    .slot32_i(slot32), .msb_first_i(msb_first), .front_i(front),
    .ch1_o(ch1), .ch2_o(ch2), .valid_o(valid)
  );

  always @(negedge clk) begin
    if (valid) begin
      vcount++;
      if (prev_v) wide++;
    end
    prev_v = valid;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic l, input logic d);
    lrck = l; sdata = d; bclk = 1'b0;
    repeat (4) @(negedge clk);
    bclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_slot(input logic l, input logic [15:0] v, input logic junk, input int nbits);
    int len = slot32 ? 32 : 24;
    int st  = !slot32 ? 8 : (front ? 0 : 16);
    for (int p = 0; p < len && p < nbits; p++) begin
      logic b;
      if (p >= st && p < st + 16) b = msb_first ? v[15-(p-st)] : v[p-st];
      else                        b = junk ^ p[0];
      drive_bit(l, b);
    end
  endtask

  task automatic frame(input logic s32, input logic msb, input logic frt,
                       input logic [15:0] a, input logic [15:0] b, input logic junk,
                       input string req);
    int v0 = vcount;
    slot32 = s32; msb_first = msb; front = frt;
    repeat (4) @(negedge clk);
    send_slot(1'b1, a, junk, 64);
    send_slot(1'b0, b, junk, 64);
    repeat (12) @(negedge clk);
    chk(ch1 == a, {req, " ch1"}, 32'(ch1), 32'(a));
    chk(ch2 == b, {req, " ch2"}, 32'(ch2), 32'(b));
    chk(vcount == v0 + 1, {req, " R7 strobe count"}, 32'(vcount - v0), 32'd1);
  endtask

  task automatic do_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset();
    chk(ch1 == 16'h0, "R1 ch1 zero", 32'(ch1), 32'h0);
    chk(ch2 == 16'h0, "R1 ch2 zero", 32'(ch2), 32'h0);
    chk(valid == 1'b0, "R1 valid low", 32'(valid), 32'h0);
  endtask

  task automatic t_short_slots;
    frame(1'b0, 1'b1, 1'b0, 16'h1234, 16'hA5C3, 1'b1, "R3 R5 24-bit msb");
    frame(1'b0, 1'b0, 1'b1, 16'h8001, 16'h7FFE, 1'b0, "R3 R5 24-bit lsb front ignored");
  endtask

  task automatic t_long_slots;
    frame(1'b1, 1'b1, 1'b1, 16'hC0DE, 16'h0F1E, 1'b1, "R4 32-bit front msb");
    frame(1'b1, 1'b0, 1'b0, 16'h9ABC, 16'h4321, 1'b0, "R4 32-bit rear lsb");
  endtask

  task automatic t_filler;
    frame(1'b1, 1'b1, 1'b0, 16'hE71B, 16'h18E4, 1'b0, "R6 filler pattern A");
    frame(1'b1, 1'b1, 1'b0, 16'hE71B, 16'h18E4, 1'b1, "R6 filler pattern B");
    frame(1'b0, 1'b0, 1'b0, 16'h3C5A, 16'hFFFF, 1'b1, "R6 24-bit filler");
  endtask

  task automatic t_orphan;
    int v0;
    frame(1'b1, 1'b1, 1'b0, 16'h5555, 16'hAAAA, 1'b0, "R2 pre-orphan");
    v0 = vcount;
    send_slot(1'b1, 16'hFFFF, 1'b1, 4);
    send_slot(1'b0, 16'h1111, 1'b1, 64);
    repeat (12) @(negedge clk);
    chk(vcount == v0, "R8 no strobe without ch1", 32'(vcount - v0), 32'd0);
    chk(ch1 == 16'h5555, "R8 ch1 held", 32'(ch1), 32'h5555);
    chk(ch2 == 16'hAAAA, "R8 ch2 held", 32'(ch2), 32'hAAAA);
    frame(1'b1, 1'b1, 1'b0, 16'h0246, 16'h8642, 1'b1, "R9 realign after cut slot");
    send_slot(1'b1, 16'h7777, 1'b0, 64);
    send_slot(1'b0, 16'h7777, 1'b0, 7);
    frame(1'b1, 1'b0, 1'b1, 16'hBEEF, 16'h0001, 1'b0, "R9 realign after cut ch2");
  endtask

  task automatic t_mid_reset;
    do_reset();
    chk(ch1 == 16'h0 && ch2 == 16'h0, "R1 mid-run reset clears", {ch1, ch2}, 32'h0);
    chk(valid == 1'b0, "R1 mid-run valid low", 32'(valid), 32'h0);
    frame(1'b0, 1'b1, 1'b0, 16'hFEDC, 16'h0123, 1'b1, "R1 R2 after reset");
  endtask

  initial begin
    t_reset();
    t_short_slots();
    t_long_slots();
    t_filler();
    t_orphan();
    t_mid_reset();
    chk(wide == 0, "R7 strobe one cycle wide", 32'(wide), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R7 watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule